// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared state of a multi-channel high-precision event timer and sits behind a simple 32-bit register port with separate read and write strobes. It contains a 64-bit main counter that advances by one each clock while the global enable bit is set and freezes while it is clear. It also holds the global configuration (enable and legacy-route bits), a read-only capability word, and a per-timer interrupt status register.

Accesses that fall into the per-timer register windows are decoded to a one-hot select for the comparator channels, which live outside this block; their read data is returned through the same port. The block tells the channels when to re-arm or disarm on enable edges. It also turns each channel's expiry into a one-clock pulse on one of the interrupt lines, which the channel's route field selects. In legacy-route mode, timers 0 and 1 instead use fixed lines. A separate output flags legacy mode so that an external legacy interval timer can be held off.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, the main counter, configuration, status, read data, interrupt lines, arm and disarm pulses and legacy_active are all zero.
- R2: A read of byte offset 0x000 returns the capability word 0x8086A201 (64-bit counter, three timers, legacy-route capable). Offset 0x004 returns the tick period in femtoseconds. Writes to 0x000 leave both unchanged.
- R3: While the enable bit is 1, the main counter increases by exactly one per clock and carries from the low half into the high half. While enable is 0, it holds its value.
- R4: While enable is 0, a write to offset 0x0F0 replaces only bits 31:0 of the counter, and a write to 0x0F4 replaces only bits 63:32. Counter writes while enable is 1 are ignored.
- R5: Read data is registered: the value appears on rdata on the clock after rd_en and holds until the next read. Offsets 0x0F0 and 0x0F4 return the low and high halves of the current (live or held) count.
- R6: The configuration register at 0x010 stores only bit 0 (global enable) and bit 1 (legacy route). All other bits read 0. Reads of 0x014 return 0.
- R7: A configuration write that changes enable from 0 to 1 pulses tmr_arm[n] for one clock for every timer whose tmr_cmp_max[n] is 0. A write that changes enable from 1 to 0 pulses tmr_disarm for one clock.
- R8: A tmr_expire[n] pulse produces a one-clock pulse on irq[route n] in the following clock, where route n is the 5-bit field tmr_route[5n+4:5n]. This happens only if tmr_en[n] and the global enable are both 1. Several timers may pulse their lines in the same clock.
- R9: While the legacy bit is 1, timer 0 pulses irq[0] and timer 1 pulses irq[8], whatever their route fields. Timers 2 and above keep using their route fields.
- R10: Status bit n at offset 0x020 is set whenever timer n delivers an interrupt. Writing a 1 to bit n clears it. A set in the same clock as a clear wins.
- R11: An access at 0x100 + 0x20*n (n below the timer count) asserts tmr_sel[n], and asserts tmr_wr or tmr_rd with it. A read returns that timer's tmr_rdata word. Windows beyond the last timer, and undecoded global offsets, select nothing and read 0.
- R12: legacy_active equals the stored legacy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tmr_sel | output | NUM_TIMERS | One-hot timer window select |
| tmr_wr | output | 1 | Write to the selected timer window |
| tmr_rd | output | 1 | Read from the selected timer window |
| tmr_offs | output | 5 | Byte offset inside the timer window |
| tmr_rdata | input | 32*NUM_TIMERS | Read words from the timer channels |
| tmr_cmp_max | input | NUM_TIMERS | Timer comparator is all-ones |
| tmr_en | input | NUM_TIMERS | Per-timer interrupt enable |
| tmr_route | input | 5*NUM_TIMERS | Per-timer interrupt line select |
| tmr_expire | input | NUM_TIMERS | Per-timer expiry pulse |
| tmr_arm | output | NUM_TIMERS | Re-arm pulse on enable rise |
| tmr_disarm | output | 1 | Disarm pulse on enable fall |
| main_count | output | 64 | Main counter value |
| irq | output | 32 | Interrupt line pulses |
| legacy_active | output | 1 | Legacy-route mode is on |

## Verification
The assertions check the following on every clock: counter stepping while enabled, counter holding while halted with no write, arm and disarm pulses appearing only on the matching enable edge, interrupt pulses only after a clock with global enable set, and status bits latching each delivered interrupt. Other behaviour only shows up in the bench's scenarios, where a behavioural model is compared on every clock. This covers the register map values, half-word counter writes and the carry across the 32-bit boundary, ignored writes to the capability register and to a running counter, legacy remapping of timers 0 and 1, set-over-clear in the status register, and the zero returned by empty timer windows.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned CNT_W   = 64;
  localparam int unsigned WIN_W   = 5;

  // word indices (addr[7:2]) of the global registers
  localparam logic [5:0] W_CAP_LO = 6'h00;
  localparam logic [5:0] W_CAP_HI = 6'h01;
  localparam logic [5:0] W_CFG_LO = 6'h04;
  localparam logic [5:0] W_CFG_HI = 6'h05;
  localparam logic [5:0] W_STAT   = 6'h08;
  localparam logic [5:0] W_CNT_LO = 6'h3C;
  localparam logic [5:0] W_CNT_HI = 6'h3D;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CAP_LO,
    SEL_CAP_HI,
    SEL_CFG_LO,
    SEL_CFG_HI,
    SEL_STAT,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_TIMER
  } reg_sel_e;
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  acc,
  output reg_sel_e              sel,
  output logic [NUM_TIMERS-1:0] tmr_hit
);
  localparam logic [WIN_W-1:0] WIN_BASE = WIN_W'(8);

  logic [WIN_W-1:0] win;
  logic             in_win_space;
  logic             win_valid;

  assign in_win_space = (addr[ADDR_W-1:8] != '0);
  assign win          = addr[ADDR_W-1:5] - WIN_BASE;
  assign win_valid    = in_win_space && (32'(win) < NUM_TIMERS);

  always_comb begin
    sel = SEL_NONE;
    if (in_win_space) begin
      if (win_valid) sel = SEL_TIMER;
    end else begin
      case (addr[7:2])
        W_CAP_LO: sel = SEL_CAP_LO;
        W_CAP_HI: sel = SEL_CAP_HI;
        W_CFG_LO: sel = SEL_CFG_LO;
        W_CFG_HI: sel = SEL_CFG_HI;
        W_STAT:   sel = SEL_STAT;
        W_CNT_LO: sel = SEL_CNT_LO;
        W_CNT_HI: sel = SEL_CNT_HI;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_hit
    assign tmr_hit[n] = acc && win_valid && (32'(win) == n);
  end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_timer_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [WIDTH-1:0] count
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic             cnt_ce;

  always_comb begin
    cnt_nxt = cnt_q;
    cnt_ce  = 1'b0;
    if (run) begin
      cnt_nxt = cnt_q + WIDTH'(1);
      cnt_ce  = 1'b1;
    end else if (wr_lo) begin
      cnt_nxt = {cnt_q[WIDTH-1:HALF], wdata[HALF-1:0]};
      cnt_ce  = 1'b1;
    end else if (wr_hi) begin
      cnt_nxt = {wdata[HALF-1:0], cnt_q[HALF-1:0]};
      cnt_ce  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_nxt;
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router #(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned ROUTE_W    = 5,
  parameter int unsigned LEG0_LINE  = 0,
  parameter int unsigned LEG1_LINE  = 8,
  localparam int unsigned NUM_IRQ   = 1 << ROUTE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          glb_en,
  input  logic                          legacy,
  input  logic [NUM_TIMERS-1:0]         tmr_en,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route,
  input  logic [NUM_TIMERS-1:0]         tmr_expire,
  output logic [NUM_TIMERS-1:0]         fire,
  output logic [NUM_IRQ-1:0]            irq
);
  logic [ROUTE_W-1:0] line [NUM_TIMERS];
  logic [NUM_IRQ-1:0] irq_nxt;
  logic [NUM_IRQ-1:0] irq_q;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_line
    if (t == 0) begin : g_leg0
      assign line[t] = legacy ? ROUTE_W'(LEG0_LINE) : tmr_route[t*ROUTE_W +: ROUTE_W];
    end else if (t == 1) begin : g_leg1
      assign line[t] = legacy ? ROUTE_W'(LEG1_LINE) : tmr_route[t*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign line[t] = tmr_route[t*ROUTE_W +: ROUTE_W];
    end
    assign fire[t] = tmr_expire[t] && tmr_en[t] && glb_en;
  end

  always_comb begin
    irq_nxt = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (fire[t]) irq_nxt[line[t]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_nxt;
  end

  assign irq = irq_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned ROUTE_W    = 5,
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [31:0] TICK_FS    = 32'd10000000,
  localparam int unsigned NUM_IRQ   = 1 << ROUTE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BUS_W-1:0]              wdata,
  output logic [BUS_W-1:0]              rdata,
  output logic [NUM_TIMERS-1:0]         tmr_sel,
  output logic                          tmr_wr,
  output logic                          tmr_rd,
  output logic [WIN_W-1:0]              tmr_offs,
  input  logic [NUM_TIMERS*BUS_W-1:0]   tmr_rdata,
  input  logic [NUM_TIMERS-1:0]         tmr_cmp_max,
  input  logic [NUM_TIMERS-1:0]         tmr_en,
  input  logic [NUM_TIMERS*ROUTE_W-1:0] tmr_route,
  input  logic [NUM_TIMERS-1:0]         tmr_expire,
  output logic [NUM_TIMERS-1:0]         tmr_arm,
  output logic                          tmr_disarm,
  output logic [CNT_W-1:0]              main_count,
  output logic [NUM_IRQ-1:0]            irq,
  output logic                          legacy_active
);
  localparam logic [31:0] CAP_LO = {VENDOR_ID, 1'b1, 1'b0, 1'b1,
                                    5'(NUM_TIMERS - 1), 8'h01};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // address decode
  reg_sel_e              sel;
  logic [NUM_TIMERS-1:0] hit;

  evt_addr_decode #(.NUM_TIMERS(NUM_TIMERS)) u_dec (
    .addr    (addr),
    .acc     (wr_en | rd_en),
    .sel     (sel),
    .tmr_hit (hit)
  );

  assign tmr_sel  = hit;
  assign tmr_wr   = wr_en && (hit != '0);
  assign tmr_rd   = rd_en && (hit != '0);
  assign tmr_offs = addr[WIN_W-1:0];

  // configuration
  logic en_q, en_nxt, leg_q, leg_nxt, cfg_wr;

  assign cfg_wr = wr_en && (sel == SEL_CFG_LO);

  always_comb begin
    en_nxt  = en_q;
    leg_nxt = leg_q;
    if (cfg_wr) begin
      en_nxt  = wdata[0];
      leg_nxt = wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q  <= 1'b0;
      leg_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q  <= en_nxt;
      leg_q <= leg_nxt;
    end
  end

  assign legacy_active = leg_q;

  // arm / disarm pulses on enable edges
  logic [NUM_TIMERS-1:0] arm_q, arm_nxt;
  logic                  dis_q, dis_nxt;

  always_comb begin
    arm_nxt = '0;
    dis_nxt = 1'b0;
    if (cfg_wr && wdata[0] && !en_q)  arm_nxt = ~tmr_cmp_max;
    if (cfg_wr && !wdata[0] && en_q)  dis_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      arm_q <= '0;
      dis_q <= 1'b0;
    end else begin
      arm_q <= arm_nxt;
      dis_q <= dis_nxt;
    end
  end

  assign tmr_arm    = arm_q;
  assign tmr_disarm = dis_q;

  // main counter
  logic cnt_wr_lo, cnt_wr_hi, cnt_wr_any;

  assign cnt_wr_lo  = wr_en && (sel == SEL_CNT_LO);
  assign cnt_wr_hi  = wr_en && (sel == SEL_CNT_HI);
  assign cnt_wr_any = cnt_wr_lo | cnt_wr_hi;

  evt_main_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (en_q),
    .wr_lo (cnt_wr_lo),
    .wr_hi (cnt_wr_hi),
    .wdata (wdata),
    .count (main_count)
  );

  // interrupt routing
  logic [NUM_TIMERS-1:0] fire;

  evt_irq_router #(
    .NUM_TIMERS (NUM_TIMERS),
    .ROUTE_W    (ROUTE_W)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_i),
    .glb_en     (en_q),
    .legacy     (leg_q),
    .tmr_en     (tmr_en),
    .tmr_route  (tmr_route),
    .tmr_expire (tmr_expire),
    .fire       (fire),
    .irq        (irq)
  );

  // status register, write one to clear, set wins
  logic [NUM_TIMERS-1:0] stat_q, stat_nxt, stat_clr;
  logic                  stat_ce;

  always_comb begin
    stat_clr = '0;
    if (wr_en && (sel == SEL_STAT)) stat_clr = wdata[NUM_TIMERS-1:0];
    stat_nxt = (stat_q & ~stat_clr) | fire;
    stat_ce  = (stat_clr != '0) || (fire != '0);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_nxt;
  end

  // read mux and registered read data
  logic [BUS_W-1:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CAP_LO: rd_mux = CAP_LO;
      SEL_CAP_HI: rd_mux = TICK_FS;
      SEL_CFG_LO: rd_mux = {{(BUS_W-2){1'b0}}, leg_q, en_q};
      SEL_CFG_HI: rd_mux = '0;
      SEL_STAT:   rd_mux = BUS_W'(stat_q);
      SEL_CNT_LO: rd_mux = main_count[BUS_W-1:0];
      SEL_CNT_HI: rd_mux = main_count[CNT_W-1:BUS_W];
      SEL_TIMER: begin
        for (int n = 0; n < NUM_TIMERS; n++) begin
          if (hit[n]) rd_mux = tmr_rdata[n*BUS_W +: BUS_W];
        end
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk #(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned NUM_IRQ    = 32
) (
  input logic                  clk,
  input logic                  rst_i,
  input logic                  en,
  input logic                  cnt_wr,
  input logic [63:0]           main_count,
  input logic [NUM_IRQ-1:0]    irq,
  input logic [NUM_TIMERS-1:0] tmr_arm,
  input logic                  tmr_disarm,
  input logic [NUM_TIMERS-1:0] fire,
  input logic [NUM_TIMERS-1:0] status
);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_i)
    en |=> main_count == $past(main_count) + 64'd1);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (!en && !cnt_wr) |=> $stable(main_count));

  assert_arm_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (tmr_arm != '0) |-> (en && !$past(en)));

  assert_disarm_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_i)
    tmr_disarm |-> (!en && $past(en)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (irq != '0) |-> $past(en));

  assert_status_latch_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (fire != '0) |=> ((status & $past(fire)) == $past(fire)));
endmodule

bind evt_timer_regs evt_timer_regs_chk #(
  .NUM_TIMERS (NUM_TIMERS),
  .NUM_IRQ    (NUM_IRQ)
) u_chk (
  .clk        (clk),
  .rst_i      (rst_i),
  .en         (en_q),
  .cnt_wr     (cnt_wr_any),
  .main_count (main_count),
  .irq        (irq),
  .tmr_arm    (tmr_arm),
  .tmr_disarm (tmr_disarm),
  .fire       (fire),
  .status     (stat_q)
);

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
  localparam int NT = 3;
  localparam int RW = 5;
  localparam int NI = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NT-1:0] tmr_sel;
  logic          tmr_wr, tmr_rd;
  logic [4:0]    tmr_offs;
  logic [NT*32-1:0] tmr_rdata;
  logic [NT-1:0] tmr_cmp_max = '0, tmr_en = '0, tmr_expire = '0;
  logic [NT*RW-1:0] tmr_route = '0;
  logic [NT-1:0] tmr_arm;
  logic          tmr_disarm;
  logic [63:0]   main_count;
  logic [NI-1:0] irq;
  logic          legacy_active;

  always #2 clk = ~clk;

  for (genvar n = 0; n < NT; n++) begin : g_rd
    assign tmr_rdata[n*32 +: 32] = 32'h5A00_0000 | (32'(n) << 16) | 32'(tmr_offs);
  end

  evt_timer_regs u_evt_timer_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_sel(tmr_sel), .tmr_wr(tmr_wr),
    .tmr_rd(tmr_rd), .tmr_offs(tmr_offs), .tmr_rdata(tmr_rdata),
    .tmr_cmp_max(tmr_cmp_max), .tmr_en(tmr_en), .tmr_route(tmr_route),
    .tmr_expire(tmr_expire), .tmr_arm(tmr_arm), .tmr_disarm(tmr_disarm),
    .main_count(main_count), .irq(irq), .legacy_active(legacy_active)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 1'b0;
  bit done    = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [63:0]   m_cnt;
  logic          m_en, m_leg;
  logic [NT-1:0] m_stat, m_arm;
  logic          m_dis;
  logic [NI-1:0] m_irq;
  logic [31:0]   m_rdata;

  function automatic logic [31:0] m_read(input int a);
    int w;
    if (a >= 'h100) begin
      w = (a - 'h100) / 32;
      if (w < NT) return 32'h5A00_0000 | (32'(w) << 16) | 32'(a % 32);
      return 32'h0;
    end
    case (a & ~3)
      'h000: return 32'h8086A201;
      'h004: return 32'd10000000;
      'h010: return {30'b0, m_leg, m_en};
      'h020: return 32'(m_stat);
      'h0F0: return m_cnt[31:0];
      'h0F4: return m_cnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int a;
    int ln;
    logic [NT-1:0] setb;
    a = int'(addr);
    if (!rst_n) begin
      m_cnt = '0; m_en = 0; m_leg = 0; m_stat = '0; m_arm = '0;
      m_dis = 0; m_irq = '0; m_rdata = '0;
    end else begin
      m_irq = '0;
      setb  = '0;
      for (int t = 0; t < NT; t++) begin
        if (tmr_expire[t] && tmr_en[t] && m_en) begin
          if (m_leg && t == 0)      ln = 0;
          else if (m_leg && t == 1) ln = 8;
          else                      ln = int'(tmr_route[t*RW +: RW]);
          m_irq[ln] = 1'b1;
          setb[t]   = 1'b1;
        end
      end
      if (rd_en) m_rdata = m_read(a);
      m_arm = '0;
      m_dis = 0;
      if (wr_en && (a & ~3) == 'h010) begin
        if (wdata[0] && !m_en) m_arm = ~tmr_cmp_max;
        if (!wdata[0] && m_en) m_dis = 1;
      end
      if (wr_en && (a & ~3) == 'h020) m_stat = m_stat & ~wdata[NT-1:0];
      m_stat = m_stat | setb;
      if (m_en) m_cnt = m_cnt + 64'd1;
      else if (wr_en && (a & ~3) == 'h0F0) m_cnt[31:0]  = wdata;
      else if (wr_en && (a & ~3) == 'h0F4) m_cnt[63:32] = wdata;
      if (wr_en && (a & ~3) == 'h010) begin
        m_en  = wdata[0];
        m_leg = wdata[1];
      end
    end
  end

  // per-clock comparison, sampled 1 ns after the edge
  always @(posedge clk) begin : compare
    logic [NT-1:0] e_sel;
    int a;
    #1;
    if (chk_on) begin
      a = int'(addr);
      e_sel = '0;
      if ((wr_en || rd_en) && a >= 'h100 && (a - 'h100) / 32 < NT)
        e_sel[(a - 'h100) / 32] = 1'b1;
      check("R3/R4 main_count", main_count, m_cnt);
      check("R2/R5/R6/R10/R11 rdata", 64'(rdata), 64'(m_rdata));
      check("R8/R9 irq", 64'(irq), 64'(m_irq));
      check("R7 tmr_arm", 64'(tmr_arm), 64'(m_arm));
      check("R7 tmr_disarm", 64'(tmr_disarm), 64'(m_dis));
      check("R12 legacy_active", 64'(legacy_active), 64'(m_leg));
      check("R11 tmr_sel", 64'(tmr_sel), 64'(e_sel));
      check("R11 tmr_wr", 64'(tmr_wr), 64'(wr_en && e_sel != '0));
      check("R11 tmr_rd", 64'(tmr_rd), 64'(rd_en && e_sel != '0));
    end
  end

  task automatic bus_wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 10'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a);
    rd_en = 1'b1; addr = 10'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expire(input logic [NT-1:0] m);
    tmr_expire = m;
    @(negedge clk);
    tmr_expire = '0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 count", main_count, 64'h0);
    check("R1 rdata", 64'(rdata), 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 legacy", 64'(legacy_active), 64'h0);
    check("R1 arm", 64'({tmr_arm, tmr_disarm}), 64'h0);
    chk_on = 1'b1;

    // R2: capability words, write to ID ignored
    bus_rd('h000); bus_rd('h004);
    bus_wr('h000, 32'hFFFF_FFFF);
    bus_rd('h000); bus_rd('h004);
    bus_rd('h008); bus_rd('h0F8);
    // R4: counter halves while halted
    bus_wr('h0F0, 32'hFFFF_FFF0);
    bus_wr('h0F4, 32'h0000_0001);
    bus_rd('h0F0); bus_rd('h0F4);
    bus_wr('h0F4, 32'h0000_0002);
    bus_rd('h0F0); bus_rd('h0F4);
    // R6 / R7: enable rise with masked bits
    tmr_cmp_max = 3'b010;
    bus_wr('h010, 32'hFFFF_FFFD);
    bus_rd('h010); bus_rd('h014);
    // R3: run through the low-half carry
    repeat (30) @(negedge clk);
    bus_rd('h0F0); bus_rd('h0F4);
    // R4: write ignored while running
    bus_wr('h0F0, 32'h1234_5678);
    bus_rd('h0F0);
    // R8: routing and gating
    tmr_en = 3'b111;
    tmr_route = {5'd20, 5'd7, 5'd3};
    expire(3'b001); expire(3'b010); expire(3'b100); expire(3'b111);
    tmr_route = {5'd9, 5'd9, 5'd31};
    expire(3'b110);
    tmr_en = 3'b011;
    expire(3'b100);
    // R10: status read, clear, set-over-clear
    bus_rd('h020);
    bus_wr('h020, 32'h0000_0001);
    bus_rd('h020);
    tmr_expire = 3'b010;
    bus_wr('h020, 32'h0000_0002);
    tmr_expire = '0;
    bus_rd('h020);
    // R9 / R12: legacy routing
    tmr_en = 3'b111;
    bus_wr('h010, 32'h0000_0003);
    expire(3'b001); expire(3'b010); expire(3'b100); expire(3'b111);
    // R7: disable, then no interrupts and held counter
    bus_wr('h010, 32'h0000_0002);
    expire(3'b111);
    repeat (5) @(negedge clk);
    bus_rd('h0F0); bus_rd('h0F4);
    bus_wr('h0F0, 32'hAAAA_5555);
    bus_rd('h0F0);
    bus_wr('h010, 32'h0000_0000);
    // R11: timer windows
    bus_rd('h100); bus_rd('h12C); bus_rd('h148);
    bus_rd('h160); bus_rd('h3FC);
    bus_wr('h124, 32'hDEAD_BEEF);
    bus_wr('h3E0, 32'h1);
    // R7: re-enable with other comparator flags
    tmr_cmp_max = 3'b101;
    bus_wr('h010, 32'h0000_0001);
    repeat (3) @(negedge clk);
    bus_rd('h0F4);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule